// File: doc/BRIEF.md
# Command/Indication Code Receive Filter

This block sits behind the deframer of a time-multiplexed serial link. Every frame carries a small command/indication code for channel 0, another for channel 1, a stop/go bit and a bus-access bit. The block turns these into a single 8-bit status word for a host. A frame strobe marks the one cycle in which the per-frame inputs are valid. The block ignores the inputs at every other time.

Channel 0 is filtered. A value is confirmed only when two consecutive frames carry it and it differs from the last confirmed value. The confirmed code is presented to the host and held there until the host reads the status word. A code that is confirmed while the previous one is still unread waits in a one-entry holder. It moves into the status word on the cycle after the read, so an unread code is never overwritten. Channel 1 is not filtered: any frame whose code differs from the previous frame raises its change flag. A read strobe marks the cycle in which the host samples the status word, and that read clears both change flags.

Top module: `ci_rx_filter`

## Requirements
- R1: After reset, status reads 8'hF3. The layout is: bits 7:4 = accepted channel-0 code, bit 3 = channel-0 change flag, bit 2 = channel-1 change flag, bit 1 = stop/go (1 stop, 0 go), bit 0 = bus access (0 this device holds the channels, 1 another device does).
- R2: A channel-0 code enters bits 7:4 only when two consecutive strobed frames carry the same value and that value differs from the last confirmed code.
- R3: While the accepted code is unread, bits 7:4 do not change. A code confirmed in that time is held pending and appears one cycle after the read cycle.
- R4: Bit 3 is set at the strobe that confirms a new channel-0 code. A one-frame glitch that returns to the confirmed value sets no flag.
- R5: Bit 2 is set at any strobe whose channel-1 code differs from the channel-1 code of the previous strobe.
- R6: A read clears bits 3 and 2. When a read and a flag-setting strobe fall in the same cycle, the flag ends up set.
- R7: Bits 1 and 0 take the stop/go and bus-access inputs at each strobe.
- R8: Input changes in cycles without a strobe have no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe marking valid frame inputs |
| ch0_code | input | 4 | Channel-0 code of the current frame |
| ch1_code | input | 4 | Channel-1 code of the current frame |
| stop_go | input | 1 | Upstream D-channel stop (1) / go (0) |
| bus_other | input | 1 | 1 when another device holds the D and C/I channels |
| rd_stb | input | 1 | Host reads status in this cycle |
| status | output | 8 | Status word (see R1) |

## Verification
The channel-0 input is driven with several patterns. A clean pair of equal frames shows that a value is accepted. A single divergent frame that reverts shows the glitch case. A repeat of the already confirmed value must be rejected. Back-to-back confirmations without a read show that the pending holder delays the new code by exactly one cycle after the read. Channel 1 gets single-frame changes, and reads are placed both alone and in the same cycle as flag-setting strobes to show that a set wins over a clear. Input changes between strobes show that they are ignored.

// File: rtl/ci_rx_pkg.sv
package ci_rx_pkg;
    localparam int CI_W = 4;
    typedef logic [CI_W-1:0] ci_code_t;

    typedef struct packed {
        ci_code_t cand;
        ci_code_t conf;
        ci_code_t code;
        ci_code_t pend_code;
        logic     pend_vld;
        logic     unread;
        logic     chg;
    } ch0_state_t;

    typedef struct packed {
        ci_code_t last;
        logic     chg;
    } ch1_state_t;

    typedef struct packed {
        logic stop;
        logic other;
    } line_state_t;
endpackage

// File: rtl/ci_ch0_confirm.sv
module ci_ch0_confirm
    import ci_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_stb,
    input  logic     rd_stb,
    input  ci_code_t code_in,
    output ci_code_t code_out,
    output logic     chg_out
);
    ch0_state_t st_d, st_q;
    logic confirm;

    always_comb begin
        st_d    = st_q;
        confirm = frame_stb && (code_in == st_q.cand) && (code_in != st_q.conf);
        if (frame_stb)
            st_d.cand = code_in;
        if (rd_stb) begin
            st_d.unread = 1'b0;
            st_d.chg    = 1'b0;
        end
        if (confirm) begin
            st_d.conf = code_in;
            st_d.chg  = 1'b1;
            if (st_q.unread) begin
                st_d.pend_code = code_in;
                st_d.pend_vld  = 1'b1;
            end else begin
                st_d.code     = code_in;
                st_d.unread   = 1'b1;
                st_d.pend_vld = 1'b0;
            end
        end else if (st_q.pend_vld && !st_q.unread) begin
            st_d.code     = st_q.pend_code;
            st_d.unread   = 1'b1;
            st_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cand      <= '1;
            st_q.conf      <= '1;
            st_q.code      <= '1;
            st_q.pend_code <= '1;
            st_q.pend_vld  <= 1'b0;
            st_q.unread    <= 1'b0;
            st_q.chg       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_out = st_q.code;
    assign chg_out  = st_q.chg;

    AST_CODE_HELD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.unread && !rd_stb) |=> $stable(st_q.code)); // R3
    AST_PEND_LOADS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_vld && !st_q.unread) |=> st_q.unread); // R3
    AST_CHG0_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.chg) |-> $past(frame_stb)); // R4
    AST_CODE_MOVES_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.code) |-> st_q.unread); // R2
endmodule

// File: rtl/ci_ch1_change.sv
module ci_ch1_change
    import ci_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_stb,
    input  logic     rd_stb,
    input  ci_code_t code_in,
    output logic     chg_out
);
    ch1_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb)
            st_d.chg = 1'b0;
        if (frame_stb) begin
            st_d.last = code_in;
            if (code_in != st_q.last)
                st_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= '1;
            st_q.chg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_out = st_q.chg;

    AST_CHG1_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frame_stb) |=> !st_q.chg); // R6
    AST_CHG1_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.chg) |-> $past(frame_stb)); // R5
endmodule

// File: rtl/ci_rx_filter.sv
module ci_rx_filter
    import ci_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb,
    input  logic [CI_W-1:0] ch0_code,
    input  logic [CI_W-1:0] ch1_code,
    input  logic            stop_go,
    input  logic            bus_other,
    input  logic            rd_stb,
    output logic [CI_W+3:0] status
);
    ci_code_t    code0;
    logic        chg0, chg1;
    line_state_t ln_d, ln_q;

    ci_ch0_confirm u_ch0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .rd_stb    (rd_stb),
        .code_in   (ch0_code),
        .code_out  (code0),
        .chg_out   (chg0)
    );

    ci_ch1_change u_ch1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .rd_stb    (rd_stb),
        .code_in   (ch1_code),
        .chg_out   (chg1)
    );

    always_comb begin
        ln_d = ln_q;
        if (frame_stb) begin
            ln_d.stop  = stop_go;
            ln_d.other = bus_other;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_q.stop  <= 1'b1;
            ln_q.other <= 1'b1;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign status = {code0, chg0, chg1, ln_q.stop, ln_q.other};

    AST_LINE_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(status[1:0])); // R8
    AST_LINE_BITS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (status[1:0] == $past({stop_go, bus_other}))); // R7
endmodule

// File: tb/ci_rx_filter_test.sv
`timescale 1ns/1ps
module ci_rx_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [3:0] ch0_code = 4'hF;
    logic [3:0] ch1_code = 4'hF;
    logic       stop_go = 1'b1;
    logic       bus_other = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ci_rx_filter uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .ch0_code(ch0_code), .ch1_code(ch1_code),
        .stop_go(stop_go), .bus_other(bus_other),
        .rd_stb(rd_stb), .status(status)
    );

    // {stb, rd, ch0, ch1, stop_go, bus_other, expected status}
    localparam logic [19:0] VEC [13] = '{
        {1'b1, 1'b0, 4'hA, 4'hF, 1'b1, 1'b1, 8'hF3}, // R2 first sample only
        {1'b1, 1'b0, 4'hA, 4'hF, 1'b1, 1'b1, 8'hAB}, // R2 R4 confirmed
        {1'b1, 1'b0, 4'h5, 4'h3, 1'b0, 1'b0, 8'hAC}, // R5 R7
        {1'b1, 1'b0, 4'hA, 4'h3, 1'b0, 1'b1, 8'hAD}, // R4 glitch, R7
        {1'b1, 1'b0, 4'hA, 4'h3, 1'b0, 1'b1, 8'hAD}, // R4 same as confirmed
        {1'b0, 1'b1, 4'hA, 4'h3, 1'b0, 1'b1, 8'hA1}, // R6 read clears
        {1'b1, 1'b0, 4'h6, 4'h3, 1'b0, 1'b1, 8'hA1}, // R2
        {1'b1, 1'b1, 4'h6, 4'h3, 1'b0, 1'b1, 8'h69}, // R6 set wins over read
        {1'b1, 1'b0, 4'hC, 4'h3, 1'b0, 1'b1, 8'h69}, // R2
        {1'b1, 1'b0, 4'hC, 4'h3, 1'b0, 1'b1, 8'h69}, // R3 held unread
        {1'b0, 1'b1, 4'hC, 4'h3, 1'b0, 1'b1, 8'hC1}, // R3 pending moves in
        {1'b1, 1'b1, 4'hC, 4'h7, 1'b0, 1'b1, 8'hC5}, // R5 R6 set wins
        {1'b0, 1'b1, 4'hC, 4'h7, 1'b0, 1'b1, 8'hC1}  // R6
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s status=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic frame(input logic [3:0] c0);
        @(negedge clk);
        ch0_code  = c0;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", status, 8'hF3);

        foreach (VEC[i]) begin
            @(negedge clk);
            frame_stb = VEC[i][19];
            rd_stb    = VEC[i][18];
            ch0_code  = VEC[i][17:14];
            ch1_code  = VEC[i][13:10];
            stop_go   = VEC[i][9];
            bus_other = VEC[i][8];
            @(negedge clk);
            frame_stb = 1'b0;
            rd_stb    = 1'b0;
            @(negedge clk);
            check($sformatf("R2-table step %0d", i), status, VEC[i][7:0]);
        end

        // R8: changes between strobes are ignored
        @(negedge clk);
        ch0_code = 4'h3; ch1_code = 4'h1; stop_go = 1'b1; bus_other = 1'b0;
        repeat (2) @(negedge clk);
        ch0_code = 4'h8;
        repeat (2) @(negedge clk);
        check("R8 no strobe no effect", status, 8'hC1);

        // R3: exact cycle of pending transfer
        ch1_code = 4'h7; stop_go = 1'b0; bus_other = 1'b1;
        frame(4'h2);
        frame(4'h2);
        @(negedge clk);
        check("R2 code 2 accepted", status, 8'h29);
        frame(4'h9);
        frame(4'h9);
        @(negedge clk);
        check("R3 unread code kept", status, 8'h29);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R3 read cycle: old code, flags clear", status, 8'h21);
        @(negedge clk);
        check("R3 pending loaded next cycle", status, 8'h91);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule